// File: doc/BRIEF.md
# Pending Interrupt Selection Unit

This unit holds the machine interrupt-pending vector of a hart and decides, every cycle, which local interrupt the hart should take, if any. A bit is a candidate only when it is both pending and enabled. Each candidate is then gated by a privilege-dependent enable. Bits that are not delegated are gated by the machine-level enable. Delegated bits are gated by the supervisor-level enable. Among the bits that survive, the lowest index wins and is reported as the cause number next to a valid flag.

Interrupt sources change the pending vector through a masked update port. Only the bits selected by the mask take the new value. The contents as they stood before the update are always visible on the old-value output. A registered hard-interrupt request line follows the pending vector's transitions between empty and non-empty, so a core can be woken or released without scanning the vector.

Top module: `irq_sel_unit`

## Requirements
- R1: A synchronous active-high reset clears the pending vector and the hard request. While the vector is empty, the valid flag is low.
- R2: When the update strobe is high at a clock edge, the pending vector becomes (old AND NOT mask) OR (value AND mask). The old-value output shows the contents from before that edge.
- R3: Only bits set in both the pending vector and the enable vector can be selected. A pending bit whose enable bit is 0 is never reported.
- R4: A bit with delegation bit 0 is eligible when the privilege is below machine (U=0, S=1, code 2), or when the privilege is machine (3) and the machine global enable is 1.
- R5: A bit with delegation bit 1 is eligible when the privilege is user (0), or when the privilege is supervisor (1) and the supervisor global enable is 1. At machine privilege (3) and at code 2 it is never eligible.
- R6: When several bits are eligible, the cause output is the index of the lowest eligible bit, in the range 0 to 31.
- R7: When no bit is eligible, the valid flag is 0 and the cause output is 0.
- R8: The hard request rises at the same edge at which the pending vector goes from all-zero to non-zero. It falls at the edge at which the vector goes from non-zero to all-zero.
- R9: An edge without the update strobe, or an update whose mask is all-zero, leaves the pending vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie | input | 1 | Machine-level global interrupt enable |
| s_gie | input | 1 | Supervisor-level global interrupt enable |
| irq_enable | input | 32 | Per-interrupt enable vector |
| irq_deleg | input | 32 | Delegation vector; 1 routes the bit to supervisor gating |
| upd_en | input | 1 | Pending-vector update strobe |
| upd_mask | input | 32 | Bits to replace on update |
| upd_value | input | 32 | Replacement values for the masked bits |
| upd_old | output | 32 | Pending-vector contents before the next edge |
| hard_req | output | 1 | Registered request: pending vector is non-empty |
| irq_valid | output | 1 | An interrupt is selected |
| irq_cause | output | 5 | Index of the selected interrupt |

## Verification
The assertions assume that the privilege, enable and delegation inputs are stable around each clock edge. They also assume that reset is held high through the first edge, so that none of the registered checks sees an undefined past. The stimulus changes every input only on the falling edge and starts with reset asserted. Privilege code 2 is driven on purpose, because the gating rules give it a defined result.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int IRQ_W   = 32;
    localparam int CAUSE_W = $clog2(IRQ_W);

    typedef logic [IRQ_W-1:0] irq_vec_t;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef struct packed {
        logic               valid;
        logic [CAUSE_W-1:0] cause;
    } irq_pick_t;

    // machine-routed bits open below machine mode or with machine enable set
    function automatic logic m_level_open(priv_e p, logic gie);
        return (p < PRIV_M) || ((p == PRIV_M) && gie);
    endfunction

    // supervisor-routed bits open below supervisor or with supervisor enable set
    function automatic logic s_level_open(priv_e p, logic gie);
        return (p < PRIV_S) || ((p == PRIV_S) && gie);
    endfunction

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_sel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     upd_en,
    input  irq_vec_t upd_mask,
    input  irq_vec_t upd_value,
    output irq_vec_t pend_q,
    output logic     hard_req
);

    irq_vec_t pend_nxt;

    assign pend_nxt = (pend_q & ~upd_mask) | (upd_value & upd_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            hard_req <= 1'b0;
        end else if (upd_en) begin
            pend_q <= pend_nxt;
            if ((pend_nxt != '0) && (pend_q == '0))
                hard_req <= 1'b1;
            else if ((pend_nxt == '0) && (pend_q != '0))
                hard_req <= 1'b0;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pend_q == '0) && !hard_req);

    // R2
    masked_write_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> pend_q == (($past(pend_q) & ~$past(upd_mask)) |
                              ($past(upd_value) & $past(upd_mask))));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd_en || (upd_mask == '0)) |=> $stable(pend_q));

    // R8
    req_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(|pend_q) |-> hard_req);

    // R8
    req_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(|pend_q) |-> !hard_req);

endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_sel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t pend_q,
    input  irq_vec_t enable,
    input  irq_vec_t deleg,
    input  priv_e    priv,
    input  logic     m_gie,
    input  logic     s_gie,
    output irq_vec_t eligible
);

    irq_vec_t armed;
    irq_vec_t m_mask;
    irq_vec_t s_mask;

    assign armed    = pend_q & enable;
    assign m_mask   = {IRQ_W{m_level_open(priv, m_gie)}};
    assign s_mask   = {IRQ_W{s_level_open(priv, s_gie)}};
    assign eligible = (armed & ~deleg & m_mask) | (armed & deleg & s_mask);

    // R3
    enabled_only_chk: assert property (@(posedge clk) disable iff (rst)
        (eligible & ~enable) == '0);

    // R4
    m_closed_chk: assert property (@(posedge clk) disable iff (rst)
        ((priv == PRIV_M) && !m_gie) |-> ((eligible & ~deleg) == '0));

    // R5
    s_closed_chk: assert property (@(posedge clk) disable iff (rst)
        ((priv == PRIV_M) || (priv == PRIV_RSV)) |-> ((eligible & deleg) == '0));

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_sel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_vec_t  eligible,
    output irq_pick_t pick
);

    irq_vec_t below;
    irq_vec_t first;

    assign below[0] = 1'b0;
    generate
        for (genvar g = 1; g < IRQ_W; g++) begin : g_chain
            assign below[g] = below[g-1] | eligible[g-1];
        end
    endgenerate

    assign first = eligible & ~below;

    always_comb begin
        pick.valid = |eligible;
        pick.cause = '0;
        for (int i = 0; i < IRQ_W; i++) begin
            if (first[i])
                pick.cause = pick.cause | CAUSE_W'(i);
        end
    end

    // R6
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> (eligible[pick.cause] &&
                        ((eligible & ((irq_vec_t'(1) << pick.cause) - 1'b1)) == '0)));

    // R7
    none_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (eligible == '0) |-> (!pick.valid && (pick.cause == '0)));

    // R6
    single_first_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(first));

endmodule

// File: rtl/irq_sel_unit.sv
module irq_sel_unit
    import irq_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         priv,
    input  logic               m_gie,
    input  logic               s_gie,
    input  logic [IRQ_W-1:0]   irq_enable,
    input  logic [IRQ_W-1:0]   irq_deleg,
    input  logic               upd_en,
    input  logic [IRQ_W-1:0]   upd_mask,
    input  logic [IRQ_W-1:0]   upd_value,
    output logic [IRQ_W-1:0]   upd_old,
    output logic               hard_req,
    output logic               irq_valid,
    output logic [CAUSE_W-1:0] irq_cause
);

    irq_vec_t  pend_q;
    irq_vec_t  eligible;
    irq_pick_t pick;
    priv_e     priv_lvl;

    assign priv_lvl = priv_e'(priv);

    irq_pend_reg u_pend (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (upd_en),
        .upd_mask  (upd_mask),
        .upd_value (upd_value),
        .pend_q    (pend_q),
        .hard_req  (hard_req)
    );

    irq_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .pend_q   (pend_q),
        .enable   (irq_enable),
        .deleg    (irq_deleg),
        .priv     (priv_lvl),
        .m_gie    (m_gie),
        .s_gie    (s_gie),
        .eligible (eligible)
    );

    irq_pick u_pick (
        .clk      (clk),
        .rst      (rst),
        .eligible (eligible),
        .pick     (pick)
    );

    assign upd_old   = pend_q;
    assign irq_valid = pick.valid;
    assign irq_cause = pick.cause;

    // R1
    empty_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_old == '0) |-> !irq_valid);

endmodule

// File: tb/irq_sel_unit_tb.sv
module irq_sel_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  priv = 2'd3;
    logic        m_gie = 1'b0;
    logic        s_gie = 1'b0;
    logic [31:0] irq_enable = '0;
    logic [31:0] irq_deleg = '0;
    logic        upd_en = 1'b0;
    logic [31:0] upd_mask = '0;
    logic [31:0] upd_value = '0;
    logic [31:0] upd_old;
    logic        hard_req;
    logic        irq_valid;
    logic [4:0]  irq_cause;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_sel_unit u_dut (
        .clk(clk), .rst(rst), .priv(priv), .m_gie(m_gie), .s_gie(s_gie),
        .irq_enable(irq_enable), .irq_deleg(irq_deleg), .upd_en(upd_en),
        .upd_mask(upd_mask), .upd_value(upd_value), .upd_old(upd_old),
        .hard_req(hard_req), .irq_valid(irq_valid), .irq_cause(irq_cause)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // expected selection, built from R3..R7
    task automatic check_pick(string req);
        logic v = 1'b0;
        logic [4:0] c = '0;
        for (int i = 31; i >= 0; i--) begin
            logic routed_s = irq_deleg[i];
            logic m_on = (priv < 2'd3) || (priv == 2'd3 && m_gie);
            logic s_on = (priv == 2'd0) || (priv == 2'd1 && s_gie);
            if (model[i] && irq_enable[i] && (routed_s ? s_on : m_on)) begin
                v = 1'b1;
                c = 5'(i);
            end
        end
        check({req, " valid"}, {31'd0, irq_valid}, {31'd0, v});
        check({req, " cause"}, {27'd0, irq_cause}, {27'd0, c});
    endtask

    task automatic update(logic [31:0] m, logic [31:0] v);
        @(negedge clk);
        upd_en = 1'b1; upd_mask = m; upd_value = v;
        #1;
        check("R2 old before edge", upd_old, model);
        @(negedge clk);
        upd_en = 1'b0;
        model = (model & ~m) | (v & m);
        #1;
        check("R2 contents", upd_old, model);
        check("R8 hard request", {31'd0, hard_req}, {31'd0, model != 0});
    endtask

    task automatic setup(logic [1:0] p, logic mg, logic sg, logic [31:0] en, logic [31:0] dl);
        @(negedge clk);
        priv = p; m_gie = mg; s_gie = sg; irq_enable = en; irq_deleg = dl;
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model = '0;
        #1;
        check("R1 pending cleared", upd_old, 32'h0);
        check("R1 hard request low", {31'd0, hard_req}, 32'd0);
        check("R1 valid low", {31'd0, irq_valid}, 32'd0);
    endtask

    task automatic t_update();
        setup(2'd3, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0);
        update(32'h0000_00F0, 32'h0000_00A5);
        check("R2 masked set", upd_old, 32'h0000_00A0);
        update(32'h0000_0030, 32'h0000_0010);
        check("R2 masked replace", upd_old, 32'h0000_0090);
        update(32'h0, 32'hFFFF_FFFF);
        check("R9 zero mask", upd_old, 32'h0000_0090);
        @(negedge clk); #1;
        check("R9 no strobe", upd_old, 32'h0000_0090);
    endtask

    task automatic t_lowest();
        setup(2'd3, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0);
        check_pick("R6 lowest of 4,7");
        check("R6 cause 4", {27'd0, irq_cause}, 32'd4);
        setup(2'd3, 1'b1, 1'b0, 32'hFFFF_FFEF, 32'h0);
        check("R3 disabled bit skipped", {27'd0, irq_cause}, 32'd7);
        setup(2'd3, 1'b1, 1'b0, 32'h0, 32'h0);
        check_pick("R3 nothing enabled");
        check("R7 cause zero", {27'd0, irq_cause}, 32'd0);
    endtask

    task automatic t_mgate();
        setup(2'd3, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0);
        check("R4 machine closed", {31'd0, irq_valid}, 32'd0);
        setup(2'd1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0);
        check_pick("R4 supervisor privilege");
        setup(2'd2, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0);
        check("R4 code 2 open", {31'd0, irq_valid}, 32'd1);
        setup(2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0);
        check_pick("R4 user privilege");
    endtask

    task automatic t_sgate();
        setup(2'd3, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R5 machine blocks delegated", {31'd0, irq_valid}, 32'd0);
        setup(2'd1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R5 supervisor closed", {31'd0, irq_valid}, 32'd0);
        setup(2'd1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check_pick("R5 supervisor open");
        setup(2'd2, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R5 code 2 blocks delegated", {31'd0, irq_valid}, 32'd0);
        setup(2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check_pick("R5 user open");
        setup(2'd3, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0010);
        check("R5 mixed routing picks 7", {27'd0, irq_cause}, 32'd7);
    endtask

    task automatic t_edges();
        setup(2'd3, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0);
        update(32'hFFFF_FFFF, 32'h8000_0000);
        check_pick("R6 bit 31");
        check("R6 cause 31", {27'd0, irq_cause}, 32'd31);
        update(32'h0000_0001, 32'h0000_0001);
        check("R6 cause 0", {27'd0, irq_cause}, 32'd0);
        update(32'hFFFF_FFFF, 32'h0);
        check("R8 request dropped", {31'd0, hard_req}, 32'd0);
        check_pick("R7 empty");
        update(32'h0000_0100, 32'h0000_0100);
        check("R8 request raised", {31'd0, hard_req}, 32'd1);
        t_reset();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_update();
        t_lowest();
        t_mgate();
        t_sgate();
        t_edges();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule